// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast feedback clock, which stands in for the oscillator signal of a synthesizer loop, by a programmable whole number. It produces one single-cycle pulse per division period for the phase comparator. The clock first passes a fixed divide-by-8 stage. A dual-modulus stage then counts those ticks in groups of 32 or 33. Two down-counters steer the modulus. A swallow count S sets how many of the groups are 33 long, and a main count M sets how many groups make up one full period. The total ratio is therefore 8·(32·M + S) clock cycles. All of it is modelled as synchronous logic on the one clock.

The ratio inputs are plain level inputs, taken from an upstream holding register. They are sampled only at the edge that ends a period, so a new setting never cuts a period short or stretches it. The block has no data stream and no handshake. The inputs are never back-pressured, and no valid/ready pair is needed. With a 6.25 kHz comparison rate, one step of (32·M + S) moves the locked oscillator by 50 kHz.

Top module: `sps_feedback_div`

## Requirements
- R1: While `rst_n` is low, `div_pulse` and `mod_ctl` are both 0.
- R2: Successive `div_pulse` rising cycles are exactly 8·(32·M + S) clock cycles apart, using the M and S in force for that period.
- R3: `div_pulse` is high for exactly one clock cycle per period.
- R4: Within each period, `mod_ctl` is 1 (divide-by-33 selected) for the first 8·33·S cycles and 0 for the rest. The count starts with the cycle in which the period's pulse is high.
- R5: `m_val` and `s_val` are sampled only on the clock edge that ends a period. Any change during a period leaves that period's length and `mod_ctl` pattern unchanged.
- R6: A value of `m_val` below 32 acts as 32.
- R7: With S = 0, `mod_ctl` stays 0 for the whole period.
- R8: The first period starts at the first rising edge with `rst_n` high and uses the values present at that edge. The first pulse goes high 8·(32·M + S) edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast feedback clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_val | input | 10 | Main count M (valid 32..1023; lower values act as 32) |
| s_val | input | 5 | Swallow count S (0..31) |
| div_pulse | output | 1 | One-cycle divided output pulse, once per period |
| mod_ctl | output | 1 | Modulus select: 1 = divide by 33, 0 = divide by 32 |

## Verification
The assertions assume only that reset is applied from time zero. They accept any `m_val` and `s_val` at any cycle, because the block itself guarantees M ≥ S through the clamp. The stimulus uses that freedom. During every period it drives random junk ratios first and switches to the wanted ratio a third of the way in, so only the value present at the closing edge can matter. M is kept at 47 or below, which holds each period near ten thousand cycles. Directed periods cover S = 0, S = 31, and two clamped values of M.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int SPS_PRE_W = 3;
  localparam int SPS_MOD_W = 5;
  localparam int SPS_M_W   = 10;
  localparam int SPS_S_W   = 5;
  localparam int SPS_M_MIN = 32;

  typedef enum logic {
    MOD_BASE  = 1'b0,
    MOD_PLUS1 = 1'b1
  } sps_mod_e;
endpackage

// File: rtl/sps_prediv.sv
module sps_prediv #(
  parameter int PRE_W = sps_pkg::SPS_PRE_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic pre_tick
);
  logic [PRE_W-1:0] pre_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_cnt <= '0;
    else if (run) pre_cnt <= pre_cnt + 1'b1;
  end

  assign pre_tick = run && (pre_cnt == {PRE_W{1'b1}});

  // R2
  pre_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> (pre_cnt == PRE_W'($past(pre_cnt) + 1'b1)));
endmodule

// File: rtl/sps_dualmod.sv
module sps_dualmod
  import sps_pkg::*;
#(
  parameter int MOD_W = SPS_MOD_W
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pre_tick,
  input  sps_mod_e mode,
  output logic     mod_tick
);
  localparam int CW = MOD_W + 1;
  localparam logic [CW-1:0] LIM_BASE  = CW'((1 << MOD_W) - 1);
  localparam logic [CW-1:0] LIM_PLUS1 = CW'(1 << MOD_W);

  logic [CW-1:0] mod_cnt;
  logic [CW-1:0] limit;

  assign limit    = (mode == MOD_PLUS1) ? LIM_PLUS1 : LIM_BASE;
  assign mod_tick = pre_tick && (mod_cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mod_cnt <= '0;
    else if (pre_tick) mod_cnt <= mod_tick ? '0 : mod_cnt + 1'b1;
  end

  // R4
  mod_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mod_cnt <= LIM_PLUS1);
endmodule

// File: rtl/sps_swallow_ctrl.sv
module sps_swallow_ctrl
  import sps_pkg::*;
#(
  parameter int M_W   = SPS_M_W,
  parameter int S_W   = SPS_S_W,
  parameter int M_MIN = SPS_M_MIN
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] m_val,
  input  logic [S_W-1:0] s_val,
  input  logic           mod_tick,
  output logic           run,
  output sps_mod_e       mode,
  output logic           div_pulse
);
  localparam logic [M_W-1:0] M_FLOOR = M_W'(M_MIN);

  logic [M_W-1:0] main_left;
  logic [S_W-1:0] sw_left;
  logic [M_W-1:0] m_eff;
  logic           last_grp;

  assign m_eff    = (m_val < M_FLOOR) ? M_FLOOR : m_val;
  assign last_grp = (main_left == M_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      main_left <= '0;
      sw_left   <= '0;
      div_pulse <= 1'b0;
    end else begin
      div_pulse <= 1'b0;
      if (!run) begin
        run       <= 1'b1;
        main_left <= m_eff;
        sw_left   <= s_val;
      end else if (mod_tick) begin
        if (last_grp) begin
          main_left <= m_eff;
          sw_left   <= s_val;
          div_pulse <= 1'b1;
        end else begin
          main_left <= main_left - 1'b1;
          if (sw_left != '0) sw_left <= sw_left - 1'b1;
        end
      end
    end
  end

  assign mode = (run && sw_left != '0) ? MOD_PLUS1 : MOD_BASE;

  // R4
  mod_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode == MOD_PLUS1) |-> $past(mod_tick));
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$past(mod_tick)) |-> ($stable(main_left) && $stable(sw_left)));
  // R6
  clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> (main_left >= M_FLOOR));
endmodule

// File: rtl/sps_feedback_div.sv
module sps_feedback_div
  import sps_pkg::*;
#(
  parameter int PRE_W = SPS_PRE_W,
  parameter int MOD_W = SPS_MOD_W,
  parameter int M_W   = SPS_M_W,
  parameter int S_W   = SPS_S_W,
  parameter int M_MIN = SPS_M_MIN
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] m_val,
  input  logic [S_W-1:0] s_val,
  output logic           div_pulse,
  output logic           mod_ctl
);
  logic     run;
  logic     pre_tick;
  logic     mod_tick;
  sps_mod_e mode;

  sps_prediv #(.PRE_W(PRE_W)) u_prediv (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .pre_tick (pre_tick)
  );

  sps_dualmod #(.MOD_W(MOD_W)) u_dualmod (
    .clk      (clk),
    .rst_n    (rst_n),
    .pre_tick (pre_tick),
    .mode     (mode),
    .mod_tick (mod_tick)
  );

  sps_swallow_ctrl #(.M_W(M_W), .S_W(S_W), .M_MIN(M_MIN)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .m_val     (m_val),
    .s_val     (s_val),
    .mod_tick  (mod_tick),
    .run       (run),
    .mode      (mode),
    .div_pulse (div_pulse)
  );

  assign mod_ctl = (mode == MOD_PLUS1);

  // R3
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);
  // R7
  zero_swallow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_pulse && $past(s_val) == '0) |-> !mod_ctl);
endmodule

// File: tb/sps_feedback_div_tb.sv
module sps_feedback_div_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] m_val;
  logic [4:0] s_val;
  logic       div_pulse;
  logic       mod_ctl;
  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  sps_feedback_div u_dut (
    .clk(clk), .rst_n(rst_n), .m_val(m_val), .s_val(s_val),
    .div_pulse(div_pulse), .mod_ctl(mod_ctl)
  );

  function automatic int exp_len(int m, int s);
    int mm;
    mm = (m < 32) ? 32 : m;
    return 8 * (32 * mm + s);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Called at the negedge where the current period is already running.
  task automatic run_period(int cm, int cs, int nm, int ns, string tag);
    int cnt;
    int hi;
    int exp;
    exp = exp_len(cm, cs);
    hi  = mod_ctl ? 1 : 0;
    cnt = 0;
    m_val = 10'($urandom_range(0, 1023));
    s_val = 5'($urandom_range(0, 31));
    forever begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) check(!div_pulse, {tag, " R3 pulse width"}, int'(div_pulse), 0);
      if (cnt == exp / 3) begin
        m_val = 10'(nm);
        s_val = 5'(ns);
      end
      if (div_pulse) break;
      if (mod_ctl) hi++;
      if (cnt > 20000) break;
    end
    check(cnt == exp, {tag, " R2 period"}, cnt, exp);
    check(hi == 264 * cs, {tag, " R4 mod_ctl high cycles"}, hi, 264 * cs);
  endtask

  initial begin
    #(1950000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    int pm, ps, nm, ns;
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    m_val = 10'd32;
    s_val = 5'd0;
    repeat (5) @(negedge clk);
    check(!div_pulse, "R1 div_pulse in reset", int'(div_pulse), 0);
    check(!mod_ctl, "R1 mod_ctl in reset", int'(mod_ctl), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: first period from the first edge after reset, with M=32,S=0 (R7)
    run_period(32, 0, 32, 31, "R8 R7");
    run_period(32, 31, 10, 5, "S=31");
    run_period(10, 5, 0, 0, "R6 M=10");
    pm = 0;
    ps = 0;
    for (int i = 0; i < 7; i++) begin
      nm = int'($urandom_range(32, 47));
      ns = int'($urandom_range(0, 31));
      run_period(pm, ps, nm, ns, (i == 0) ? "R6 R7 M=0" : "R5 random");
      pm = nm;
      ps = ns;
    end
    run_period(pm, ps, 32, 0, "R5 last");
    finish_run();
  end
endmodule